// File: doc/BRIEF.md
# Three-Term Polynomial Product Unit

This block multiplies two second-degree polynomials. Each operand has three unsigned coefficients of a configurable width, and the block returns the five coefficients of the product. The arithmetic is fully combinational and uses the generalized Karatsuba scheme. Three products come from like-indexed coefficient pairs, D_i = a_i·b_i. Three more come from sums of coefficient pairs, D_pq = (a_p + a_q)·(b_p + b_q) for q > p. That makes six multipliers where the schoolbook method needs nine. Each output coefficient is then formed from these shared products using only adders and subtractors.

A single register stage sits on the result. When `in_valid` is high at a clock edge, the product of the presented operands appears on the next cycle together with `out_valid`. While `in_valid` is low, the registered result does not change, whatever the operand inputs do.

Operand coefficient k sits at bits [k*W +: W] of its input vector. Product coefficient i sits at bits [i*CW +: CW] of `c_vec`, where CW = 2W+3.

Top module: `kara_poly3_mul`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and every bit of `c_vec` become 0. After reset and before the first accepted operand, `c_vec` stays 0.
- R2: `out_valid` is high in exactly the cycle after a clock edge at which `in_valid` was high. Each accepted operand pair yields one result, and results come out in acceptance order.
- R3: Coefficient 0 of the result (bits [0 +: CW]) equals a0·b0.
- R4: Coefficient 4 of the result (bits [4*CW +: CW]) equals a2·b2.
- R5: Coefficient 1 of the result equals a0·b1 + a1·b0.
- R6: Coefficient 3 of the result equals a1·b2 + a2·b1.
- R7: Coefficient 2 of the result equals a0·b2 + a1·b1 + a2·b0.
- R8: With every operand coefficient at 2^W−1, every result coefficient is exact, with no wrap. In that case coefficient 2 is 3·(2^W−1)².
- R9: At a clock edge where `in_valid` is low, `c_vec` keeps its value, even if the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are presented this cycle |
| a_vec | input | 3*W | First polynomial, coefficient k at [k*W +: W] |
| b_vec | input | 3*W | Second polynomial, coefficient k at [k*W +: W] |
| out_valid | output | 1 | `c_vec` holds a new product this cycle |
| c_vec | output | 5*(2W+3) | Product polynomial, coefficient i at [i*CW +: CW] |

## Verification
The bench targets the all-ones operands. There the middle coefficient is largest and the pair sums carry into their extra bit, so a sum or difference sized one bit short would wrap and report a small wrong number. Operands with a single nonzero coefficient expose a pair term assigned to the wrong output index, and zero operands expose a subtraction that leaves a residue. Random operand changes during idle cycles catch a register that loads without `in_valid`. Back-to-back transfers catch a valid flag or result that slips by a cycle.

// File: rtl/kpm_pkg.sv
// Package: shared constants and pair-index helpers for the 3-term
// Karatsuba product unit. Assumes operands of exactly three coefficients.
package kpm_pkg;
    localparam int NUM_TERMS = 3;
    localparam int NUM_PAIRS = 3;
    localparam int NUM_OUT   = 2 * NUM_TERMS - 1;

    // Lower index of pair k: pairs are (0,1), (0,2), (1,2)
    function automatic int pair_lo(input int k);
        return (k == 2) ? 1 : 0;
    endfunction

    // Upper index of pair k
    function automatic int pair_hi(input int k);
        return (k == 0) ? 1 : 2;
    endfunction
endpackage

// File: rtl/kpm_pair_sum.sv
// Pair adder: forms a_p + a_q and b_p + b_q for each index pair q > p.
// Assumes unsigned coefficients; each sum is one bit wider than W.
module kpm_pair_sum
    import kpm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NUM_TERMS*W-1:0]     a_vec,
    input  logic [NUM_TERMS*W-1:0]     b_vec,
    output logic [NUM_PAIRS*(W+1)-1:0] sa_vec,
    output logic [NUM_PAIRS*(W+1)-1:0] sb_vec
);
    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        localparam int LO = pair_lo(k);
        localparam int HI = pair_hi(k);
        // Widen both terms before adding so the carry is kept
        assign sa_vec[k*(W+1) +: W+1] = {1'b0, a_vec[LO*W +: W]} + {1'b0, a_vec[HI*W +: W]};
        assign sb_vec[k*(W+1) +: W+1] = {1'b0, b_vec[LO*W +: W]} + {1'b0, b_vec[HI*W +: W]};
    end
endmodule

// File: rtl/kpm_products.sv
// Product bank: the three like-index products and the three pair-sum
// products that all output coefficients share. Six multipliers in total.
module kpm_products
    import kpm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NUM_TERMS*W-1:0]       a_vec,
    input  logic [NUM_TERMS*W-1:0]       b_vec,
    input  logic [NUM_PAIRS*(W+1)-1:0]   sa_vec,
    input  logic [NUM_PAIRS*(W+1)-1:0]   sb_vec,
    output logic [NUM_TERMS*2*W-1:0]     d_single,
    output logic [NUM_PAIRS*(2*W+2)-1:0] d_pair
);
    localparam int SW = 2 * W;
    localparam int PW = 2 * W + 2;

    for (genvar i = 0; i < NUM_TERMS; i++) begin : g_single
        // Like-index product D_i
        assign d_single[i*SW +: SW] = SW'(a_vec[i*W +: W]) * SW'(b_vec[i*W +: W]);
    end

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pairp
        // Pair-sum product D_pq
        assign d_pair[k*PW +: PW] = PW'(sa_vec[k*(W+1) +: W+1]) * PW'(sb_vec[k*(W+1) +: W+1]);
    end
endmodule

// File: rtl/kpm_combine.sv
// Coefficient combiner: c_i = sum over pairs p+q=i of (D_pq - D_p - D_q),
// plus D_(i/2) for even i. Every difference stays non-negative because
// D_pq contains both D_p and D_q. Assumes CW is at least 2W+2.
module kpm_combine
    import kpm_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 2 * W + 3
) (
    input  logic [NUM_TERMS*2*W-1:0]     d_single,
    input  logic [NUM_PAIRS*(2*W+2)-1:0] d_pair,
    output logic [NUM_OUT*CW-1:0]        c_comb
);
    localparam int SW = 2 * W;
    localparam int PW = 2 * W + 2;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_coef
        logic [CW-1:0] acc;
        // Sum the pair terms and the middle single product for coefficient i
        always_comb begin
            acc = '0;
            for (int k = 0; k < NUM_PAIRS; k++) begin
                if (pair_lo(k) + pair_hi(k) == i) begin
                    acc = acc + CW'(d_pair[k*PW +: PW])
                              - CW'(d_single[pair_lo(k)*SW +: SW])
                              - CW'(d_single[pair_hi(k)*SW +: SW]);
                end
            end
            if ((i % 2) == 0) begin
                acc = acc + CW'(d_single[(i/2)*SW +: SW]);
            end
        end
        assign c_comb[i*CW +: CW] = acc;
    end
endmodule

// File: rtl/kara_poly3_mul.sv
// Top: Karatsuba product of two three-coefficient polynomials with one
// output register stage. Loads on in_valid, holds otherwise.
// Synchronous active-low reset clears the result and the valid flag.
module kara_poly3_mul
    import kpm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [3*W-1:0]                 a_vec,
    input  logic [3*W-1:0]                 b_vec,
    output logic                           out_valid,
    output logic [5*(2*W+3)-1:0]           c_vec
);
    localparam int CW = 2 * W + 3;

    logic [NUM_PAIRS*(W+1)-1:0]   sa_vec;
    logic [NUM_PAIRS*(W+1)-1:0]   sb_vec;
    logic [NUM_TERMS*2*W-1:0]     d_single;
    logic [NUM_PAIRS*(2*W+2)-1:0] d_pair;
    logic [NUM_OUT*CW-1:0]        c_comb;

    kpm_pair_sum #(.W(W)) u_sum (
        .a_vec  (a_vec),
        .b_vec  (b_vec),
        .sa_vec (sa_vec),
        .sb_vec (sb_vec)
    );

    kpm_products #(.W(W)) u_prod (
        .a_vec    (a_vec),
        .b_vec    (b_vec),
        .sa_vec   (sa_vec),
        .sb_vec   (sb_vec),
        .d_single (d_single),
        .d_pair   (d_pair)
    );

    kpm_combine #(.W(W), .CW(CW)) u_comb (
        .d_single (d_single),
        .d_pair   (d_pair),
        .c_comb   (c_comb)
    );

    // Output register: capture the product on in_valid, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            c_vec     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                c_vec <= c_comb;
            end
        end
    end
endmodule

// File: rtl/kara_poly3_mul_chk.sv
// Checker: compares the registered result against the operands accepted
// one cycle earlier, written as direct convolution terms.
module kara_poly3_mul_chk #(
    parameter int W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [3*W-1:0]       a_vec,
    input logic [3*W-1:0]       b_vec,
    input logic                 out_valid,
    input logic [5*(2*W+3)-1:0] c_vec
);
    localparam int CW = 2 * W + 3;

    logic [CW-1:0] a0, a1, a2, b0, b1, b2;
    logic [CW-1:0] c0, c1, c2, c3, c4;

    assign a0 = CW'(a_vec[0*W +: W]);
    assign a1 = CW'(a_vec[1*W +: W]);
    assign a2 = CW'(a_vec[2*W +: W]);
    assign b0 = CW'(b_vec[0*W +: W]);
    assign b1 = CW'(b_vec[1*W +: W]);
    assign b2 = CW'(b_vec[2*W +: W]);
    assign c0 = c_vec[0*CW +: CW];
    assign c1 = c_vec[1*CW +: CW];
    assign c2 = c_vec[2*CW +: CW];
    assign c3 = c_vec[3*CW +: CW];
    assign c4 = c_vec[4*CW +: CW];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(c_vec)); // R9
    AST_LOW_COEF: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> c0 == $past(a0 * b0)); // R3
    AST_HIGH_COEF: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> c4 == $past(a2 * b2)); // R4
    AST_FIRST_COEF: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> c1 == $past(a0 * b1 + a1 * b0)); // R5
    AST_THIRD_COEF: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> c3 == $past(a1 * b2 + a2 * b1)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> c2 == $past(a0 * b2 + a1 * b1 + a2 * b0)); // R7
endmodule

bind kara_poly3_mul kara_poly3_mul_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_vec     (a_vec),
    .b_vec     (b_vec),
    .out_valid (out_valid),
    .c_vec     (c_vec)
);

// File: tb/kara_poly3_mul_tb_top.sv
// Scoreboard bench: the driver pushes convolution results, the monitor
// pops and compares them as out_valid results arrive.
module kara_poly3_mul_tb_top;
    localparam int W  = 8;
    localparam int CW = 2 * W + 3;
    localparam logic [W-1:0] MAXC = {W{1'b1}};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [3*W-1:0]      a_vec = '0;
    logic [3*W-1:0]      b_vec = '0;
    logic                out_valid;
    logic [5*CW-1:0]     c_vec;

    int checks = 0;
    int errors = 0;
    logic [5*CW-1:0] exp_q[$];
    bit              max_q[$];
    logic [5*CW-1:0] last_c = '0;
    bit              mon_on = 1'b0;

    always #10 clk = ~clk;

    kara_poly3_mul #(.W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a_vec     (a_vec),
        .b_vec     (b_vec),
        .out_valid (out_valid),
        .c_vec     (c_vec)
    );

    function automatic logic [5*CW-1:0] conv(input logic [3*W-1:0] a, input logic [3*W-1:0] b);
        longint unsigned c[5];
        logic [5*CW-1:0] r;
        for (int i = 0; i < 5; i++) c[i] = 0;
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                c[i+j] += longint'(a[i*W +: W]) * longint'(b[j*W +: W]);
        for (int i = 0; i < 5; i++) r[i*CW +: CW] = CW'(c[i]);
        return r;
    endfunction

    task automatic check(input string req, input logic [CW*5-1:0] act, input logic [CW*5-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3*W-1:0] a, input logic [3*W-1:0] b, input bit is_max);
        @(negedge clk);
        in_valid = 1'b1;
        a_vec = a;
        b_vec = b;
        exp_q.push_back(conv(a, b));
        max_q.push_back(is_max);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a_vec = 3*W'($urandom);
            b_vec = 3*W'($urandom);
        end
    endtask

    // Monitor: compare arriving results, and check holding when idle
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 actual=unexpected out_valid expected=none");
                end else begin
                    logic [5*CW-1:0] e;
                    bit m;
                    e = exp_q.pop_front();
                    m = max_q.pop_front();
                    check("R3", 5*CW'(c_vec[0*CW +: CW]), 5*CW'(e[0*CW +: CW]));
                    check("R5", 5*CW'(c_vec[1*CW +: CW]), 5*CW'(e[1*CW +: CW]));
                    check(m ? "R7 R8" : "R7", 5*CW'(c_vec[2*CW +: CW]), 5*CW'(e[2*CW +: CW]));
                    check("R6", 5*CW'(c_vec[3*CW +: CW]), 5*CW'(e[3*CW +: CW]));
                    check("R4", 5*CW'(c_vec[4*CW +: CW]), 5*CW'(e[4*CW +: CW]));
                    last_c = c_vec;
                end
            end else begin
                check("R9", c_vec, last_c);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 actual=watchdog expired expected=run complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Main sequence
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {{(5*CW-1){1'b0}}, out_valid}, '0);
        check("R1", c_vec, '0);
        mon_on = 1'b1;
        idle(2);
        drive('0, '0, 1'b0);
        drive({MAXC, MAXC, MAXC}, {MAXC, MAXC, MAXC}, 1'b1);
        idle(3);
        drive({8'd0, 8'd0, 8'd5}, {8'd7, 8'd3, 8'd2}, 1'b0);
        drive({8'd0, 8'd9, 8'd0}, {8'd1, 8'd0, 8'd4}, 1'b0);
        drive({8'd11, 8'd0, 8'd0}, {8'd0, 8'd0, 8'd13}, 1'b0);
        drive({MAXC, 8'd1, MAXC}, {8'd1, MAXC, 8'd1}, 1'b0);
        idle(2);
        for (int i = 0; i < 40; i++) begin
            drive(3*W'($urandom), 3*W'($urandom), 1'b0);
            if (i % 5 == 0) idle(1);
        end
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 actual=%0d pending expected=0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule